// File: doc/BRIEF.md
# Codec Power Management Sequencer

This block keeps the 8-bit power control word of a stereo audio converter and turns it into separate power enables. There are enables for the left and right DAC, the left and right ADC, the left and right microphone amplifier, the microphone supply pin and the common-mode reference. Software writes the word over a simple parallel write port and reads it back on a parallel read port. The block enforces the reference interlock. While any other block is enabled, the reference enable is held on, whatever value was written for the reference bit.

When either ADC channel turns on, the block counts a start-up period of sample-rate strobes before it raises the ADC-data-valid flag. A hard power-down input, active low, clears the word asynchronously and switches every enable off. Writing an all-zero word also switches everything off, but only through the normal write path.

Top module: `codec_pwr_seq`

## Requirements
- R1: Each bit of the stored word drives one enable, and a value of 1 means on. The mapping is: bit 7 drives the right DAC, bit 6 the left DAC, bit 5 the right ADC, bit 4 the left ADC, bit 3 the right microphone amplifier, bit 2 the left microphone amplifier, bit 1 the microphone supply, and bit 0 the common-mode reference.
- R2: While `pdn_n` is low, the stored word is 0x00 and every enable and `adc_valid` are 0. Writes made during that time are ignored, and after release the word reads 0x00.
- R3: `rd_data` always shows the stored word. The word is replaced one clock after a write, so a write of 0x00 switches every enable off and reads back 0x00.
- R4: When any of bits 7..1 in a written word is 1, bit 0 is stored as 1 even if it was written as 0. The other bits are stored as written.
- R5: When bits 7..1 of a written word are all 0, bit 0 is stored exactly as written, so the reference can be switched off.
- R6: A write that changes bit 5 or bit 4 from 0 to 1 starts a count of INIT_SAMPLES (default 1059) `fs_strobe` pulses. `adc_valid` stays 0 until the pulse that ends the count and reads 1 on the clock after that pulse.
- R7: A new 0-to-1 change of an ADC bit during a count, or after the count has finished, clears `adc_valid` and restarts the full count. A strobe that arrives in the same cycle as such a write is not counted.
- R8: A write that leaves bits 5 and 4 both 0 clears `adc_valid` on the next clock and stops the count.
- R9: A write that keeps an ADC bit at 1 without a new 0-to-1 change leaves `adc_valid` and the running count unchanged.
- R10: When bit 1 is 0, `mic_sup_oe` is 0, so the supply pin is high-impedance. When bit 1 is 1, `mic_sup_oe` and `mic_sup_lvl` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Hard power-down, active low, asynchronous |
| fs_strobe | input | 1 | One-cycle pulse per sample period |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Word to write |
| rd_data | output | 8 | Stored control word |
| dac_r_en | output | 1 | Right DAC enable |
| dac_l_en | output | 1 | Left DAC enable |
| adc_r_en | output | 1 | Right ADC enable |
| adc_l_en | output | 1 | Left ADC enable |
| mic_r_en | output | 1 | Right microphone amplifier enable |
| mic_l_en | output | 1 | Left microphone amplifier enable |
| mic_sup_lvl | output | 1 | Level driven onto the microphone supply pin |
| mic_sup_oe | output | 1 | Output enable of the microphone supply pin (0 means high-impedance) |
| vref_en | output | 1 | Common-mode reference enable |
| adc_valid | output | 1 | ADC output data is valid |

## Verification
The main collision is a control write that turns on an ADC channel in the same cycle as a sample strobe. The reload has to win, and the strobe must not be counted toward the new period. The bench provokes this in the middle of a running count by writing a second ADC channel while `fs_strobe` is high. It then requires `adc_valid` to stay low after INIT_SAMPLES-1 further strobes and to rise only after the last one. A second collision, a write that clears both ADC bits while a strobe is pending, is judged by requiring `adc_valid` to stay low through a long run of strobes.

// File: rtl/codec_pwr_seq.sv
`timescale 1ns/1ps
module codec_pwr_seq #(
  parameter int INIT_SAMPLES = 1059,
  localparam int CNT_W = $clog2(INIT_SAMPLES + 1)
) (
  input  logic       clk,
  input  logic       pdn_n,
  input  logic       fs_strobe,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       dac_r_en,
  output logic       dac_l_en,
  output logic       adc_r_en,
  output logic       adc_l_en,
  output logic       mic_r_en,
  output logic       mic_l_en,
  output logic       mic_sup_lvl,
  output logic       mic_sup_oe,
  output logic       vref_en,
  output logic       adc_valid
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(INIT_SAMPLES);

  logic [7:0]       ctl_q;
  logic [7:0]       ctl_d;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             valid_q;
  logic             adc_rise;
  logic [1:0]       adc_next;

  assign ctl_d    = {wr_data[7:1], wr_data[0] | (|wr_data[7:1])};
  assign adc_rise = wr_en && ((ctl_d[5] && !ctl_q[5]) || (ctl_d[4] && !ctl_q[4]));
  assign adc_next = wr_en ? ctl_d[5:4] : ctl_q[5:4];

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      ctl_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= ctl_d;
      if (adc_rise) begin
        cnt_q   <= LOAD;
        busy_q  <= 1'b1;
        valid_q <= 1'b0;
      end else if (adc_next == 2'b00) begin
        cnt_q   <= '0;
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if (busy_q && fs_strobe) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign rd_data     = ctl_q;
  assign dac_r_en    = pdn_n & ctl_q[7];
  assign dac_l_en    = pdn_n & ctl_q[6];
  assign adc_r_en    = pdn_n & ctl_q[5];
  assign adc_l_en    = pdn_n & ctl_q[4];
  assign mic_r_en    = pdn_n & ctl_q[3];
  assign mic_l_en    = pdn_n & ctl_q[2];
  assign mic_sup_oe  = pdn_n & ctl_q[1];
  assign mic_sup_lvl = pdn_n & ctl_q[1];
  assign vref_en     = pdn_n & ctl_q[0];
  assign adc_valid   = pdn_n & valid_q;

  // R4
  ref_interlock_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    (|ctl_q[7:1]) |-> ctl_q[0]);

  // R8
  adc_off_invalid_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    (ctl_q[5:4] == 2'b00) |-> !valid_q);

  // R6
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(valid_q) |-> ($past(busy_q) && $past(fs_strobe)));

  // R7
  reload_on_rise_chk: assert property (@(posedge clk) disable iff (!pdn_n)
    adc_rise |=> (busy_q && !valid_q && cnt_q == LOAD));
endmodule

// File: tb/codec_pwr_seq_tb.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb_top;
  localparam int INIT = 1059;

  logic       clk = 1'b0;
  logic       pdn_n = 1'b0;
  logic       fs_strobe = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic dac_r_en, dac_l_en, adc_r_en, adc_l_en, mic_r_en, mic_l_en;
  logic mic_sup_lvl, mic_sup_oe, vref_en, adc_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  codec_pwr_seq #(.INIT_SAMPLES(INIT)) dut_i (
    .clk(clk), .pdn_n(pdn_n), .fs_strobe(fs_strobe), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .dac_r_en(dac_r_en),
    .dac_l_en(dac_l_en), .adc_r_en(adc_r_en), .adc_l_en(adc_l_en),
    .mic_r_en(mic_r_en), .mic_l_en(mic_l_en), .mic_sup_lvl(mic_sup_lvl),
    .mic_sup_oe(mic_sup_oe), .vref_en(vref_en), .adc_valid(adc_valid));

  function automatic logic [7:0] stored(input logic [7:0] w);
    return {w[7:1], w[0] | (|w[7:1])};
  endfunction

  function automatic logic [7:0] enables();
    return {dac_r_en, dac_l_en, adc_r_en, adc_l_en, mic_r_en, mic_l_en, mic_sup_lvl, vref_en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit s);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; fs_strobe = s;
    @(negedge clk);
    wr_en = 1'b0; fs_strobe = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fs_strobe = 1'b1;
      @(negedge clk); fs_strobe = 1'b0;
    end
  endtask

  task automatic chk_word(input logic [7:0] e, input string req);
    chk(rd_data == e, req, rd_data, e);
    chk(enables() == e, req, enables(), e);
    chk(mic_sup_oe == e[1], "R10 supply oe", mic_sup_oe, e[1]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk_word(8'h00, "R2 reset");
    chk(adc_valid == 1'b0, "R2 valid reset", adc_valid, 0);
    wr(8'hFF, 1'b0);
    chk(rd_data == 8'h00, "R2 write ignored in power-down", rd_data, 0);
    pdn_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R10 directed corners
    wr(8'h80, 1'b0); chk_word(8'h81, "R4 dac right sets ref");
    wr(8'h02, 1'b0); chk_word(8'h03, "R10 supply on");
    chk(mic_sup_lvl == 1'b1, "R10 supply level", mic_sup_lvl, 1);
    wr(8'h01, 1'b0); chk_word(8'h01, "R5 ref only");
    chk(mic_sup_oe == 1'b0, "R10 hi-z", mic_sup_oe, 0);
    wr(8'h00, 1'b0); chk_word(8'h00, "R5 ref off");
    wr(8'h4C, 1'b0); chk_word(8'h4D, "R1 mapping");
    wr(8'h00, 1'b0); chk_word(8'h00, "R3 all zero write");

    // R1 R4 R5 random writes
    for (int k = 0; k < 40; k++) begin
      w = 8'($urandom);
      wr(w, 1'b0);
      chk_word(stored(w), "R4 random write");
    end
    wr(8'h00, 1'b0);

    // R6 basic init
    wr(8'h10, 1'b0);
    chk(adc_valid == 1'b0, "R6 valid low at start", adc_valid, 0);
    strobes(INIT - 1);
    chk(adc_valid == 1'b0, "R6 one strobe short", adc_valid, 0);
    strobes(1);
    chk(adc_valid == 1'b1, "R6 valid after full count", adc_valid, 1);

    // R9 no new rise keeps valid
    wr(8'h1C, 1'b0);
    chk(adc_valid == 1'b1, "R9 valid kept", adc_valid, 1);

    // R7 reload after finish, in same cycle as strobe
    wr(8'h3C, 1'b1);
    chk(adc_valid == 1'b0, "R7 valid cleared by new rise", adc_valid, 0);
    strobes(500);
    // R7 collision mid-count: drop right then re-raise it with a strobe
    wr(8'h1C, 1'b0);
    strobes(10);
    wr(8'h3C, 1'b1);
    strobes(INIT - 1);
    chk(adc_valid == 1'b0, "R7 reload strobe not counted", adc_valid, 0);
    strobes(1);
    chk(adc_valid == 1'b1, "R7 valid after reload", adc_valid, 1);

    // R8 abort with strobe pending
    wr(8'h10, 1'b0);
    strobes(100);
    wr(8'h01, 1'b1);
    chk(adc_valid == 1'b0, "R8 abort", adc_valid, 0);
    wr(8'h20, 1'b0);
    strobes(INIT - 1);
    chk(adc_valid == 1'b0, "R8 restart counts fully", adc_valid, 0);
    strobes(1);
    chk(adc_valid == 1'b1, "R6 right channel init", adc_valid, 1);
    wr(8'h00, 1'b0);
    chk(adc_valid == 1'b0, "R8 all zero drops valid", adc_valid, 0);
    strobes(INIT + 5);
    chk(adc_valid == 1'b0, "R8 stays low while off", adc_valid, 0);

    // R2 hard power-down
    wr(8'hF7, 1'b0);
    @(negedge clk); pdn_n = 1'b0;
    @(negedge clk);
    chk_word(8'h00, "R2 power-down forces off");
    pdn_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R2 default after release", rd_data, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule